// File: doc/BRIEF.md
# Hardwired Fetch and Branch Sequencer

This block is the control unit of a small processor whose datapath moves values over one shared bus. A one-hot timing-step register walks through the steps of an instruction. Combinational sum-of-products logic turns the current step, the class of the opcode held in the instruction register and two condition inputs into single-bit control strobes for the datapath. The datapath is outside the block.

The first three steps fetch an instruction and are the same for every opcode. Step 0 drives the program counter onto the bus and latches it as the memory address. Step 1 reads memory into the buffer register and adds four to the program counter. Step 2 copies the buffer into the instruction register.

From step 3 on, the strobes depend on the opcode. There are sequences for a conditional branch, a branch that saves a link address, and a right shift. The condition input gates the writes to the program counter and to the register file, and the shift-count-is-zero input gates a reload of the shift count. After the last step of each sequence the step register goes back to step 0. Every pin is a plain control level: nothing flows in or out as a stream, so the block has no valid/ready handshake.

Top module: `hw_seq_ctrl`

## Requirements
- R1: While reset is asserted, and on the first cycle after reset is released, `step_o` equals 8'h01 (step 0). `step_o` has exactly one bit set in every cycle. Bit k of `step_o` means step k. A reset in the middle of a sequence returns the block to step 0.
- R2: At step 0, for every opcode and condition value, only `pc_drive`, `mar_load` and `alu_pass` are high.
- R3: At step 1, only `pc_drive`, `pc_inc`, `pc_load`, `mem_read`, `mar_drive` and `mbr_load` are high.
- R4: At step 2, only `mbr_drive`, `alu_pass` and `ir_load` are high.
- R5: For opcode `OP_BR` (default 8): step 3 raises only `cond_load`, `rc_sel` and `reg_to_bus`. Step 4 raises only `rb_sel` and `reg_to_bus`, and also `pc_load` when `cond_bit` is 1.
- R6: For opcode `OP_BRL` (default 9): step 3 is the same as for `OP_BR`. When `cond_bit` is 1, step 4 raises only `ra_sel`, `bus_to_reg` and `pc_drive`; when it is 0, step 4 raises no strobe. Step 5 raises `rb_sel` and `reg_to_bus`, and also `pc_load` when `cond_bit` is 1.
- R7: For opcode `OP_SHR` (default 26):
  - step 3 raises only `cnt_load`;
  - step 4 raises `rc_sel` and `reg_to_bus`, and also `cnt_load` when `shamt_zero` is 1;
  - step 5 raises only `c_load` and `shift_en`;
  - step 6 raises only `c_drive`, `ra_sel` and `bus_to_reg`.
- R8: For any other opcode, step 3 raises no strobe at all.
- R9: In any cycle, at most one of the bus sources `pc_drive`, `mbr_drive`, `reg_to_bus` and `c_drive` is high.
- R10: After its last step, each sequence goes back to step 0. The last step is step 4 for `OP_BR`, step 5 for `OP_BRL`, step 6 for `OP_SHR` and step 3 for any other opcode. A sequence therefore lasts 5, 6, 7 or 4 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| opcode | input | OPW (5) | Opcode field from the instruction register |
| cond_bit | input | 1 | Latched branch condition |
| shamt_zero | input | 1 | High when the immediate shift count is zero |
| step_o | output | NSTEPS (8) | One-hot current timing step |
| pc_drive | output | 1 | Program counter drives the bus |
| pc_inc | output | 1 | Adder increments the program counter by four |
| pc_load | output | 1 | Program counter loads |
| mar_load | output | 1 | Memory address register loads |
| mar_drive | output | 1 | Memory address register drives the memory address |
| mem_read | output | 1 | Memory read |
| mbr_load | output | 1 | Memory buffer loads |
| mbr_drive | output | 1 | Memory buffer drives the bus |
| ir_load | output | 1 | Instruction register loads |
| alu_pass | output | 1 | ALU passes its bus input straight through |
| cond_load | output | 1 | Condition flip-flop loads |
| ra_sel | output | 1 | Register file selects field ra |
| rb_sel | output | 1 | Register file selects field rb |
| rc_sel | output | 1 | Register file selects field rc |
| reg_to_bus | output | 1 | Selected register drives the bus |
| bus_to_reg | output | 1 | Selected register loads from the bus |
| cnt_load | output | 1 | Shift count register loads |
| shift_en | output | 1 | Shifter operates on the way into C |
| c_load | output | 1 | Result register C loads |
| c_drive | output | 1 | Result register C drives the bus |

## Verification
The bench builds the block with its default parameters: a 5-bit opcode, eight timing steps, and the three opcodes at 8, 9 and 26. With these values, each known sequence runs with both levels of `cond_bit` and of `shamt_zero`. Opcode 0, opcode 31 and the neighbours of the known opcodes exercise the short path for an unknown opcode. Because the sequences run back to back, the return to step 0 after each length is checked by the first fetch step of the following sequence.

// File: rtl/ctl_seq_pkg.sv
package ctl_seq_pkg;

  // Fixed step indices shared by every sequence
  localparam int unsigned ST_ADDR  = 0;
  localparam int unsigned ST_READ  = 1;
  localparam int unsigned ST_IR    = 2;
  localparam int unsigned ST_EX0   = 3;
  localparam int unsigned ST_EX1   = 4;
  localparam int unsigned ST_EX2   = 5;
  localparam int unsigned ST_EX3   = 6;

  // Last step of each opcode class
  localparam int unsigned LAST_BR    = ST_EX1;
  localparam int unsigned LAST_BRL   = ST_EX2;
  localparam int unsigned LAST_SHR   = ST_EX3;
  localparam int unsigned LAST_OTHER = ST_EX0;

  // One-hot opcode class
  typedef struct packed {
    logic br;
    logic brl;
    logic shr;
    logic other;
  } op_class_t;

  // Complete strobe set
  typedef struct packed {
    logic pc_drive;
    logic pc_inc;
    logic pc_load;
    logic mar_load;
    logic mar_drive;
    logic mem_read;
    logic mbr_load;
    logic mbr_drive;
    logic ir_load;
    logic alu_pass;
    logic cond_load;
    logic ra_sel;
    logic rb_sel;
    logic rc_sel;
    logic reg_to_bus;
    logic bus_to_reg;
    logic cnt_load;
    logic shift_en;
    logic c_load;
    logic c_drive;
  } strobe_t;

endpackage

// File: rtl/seq_step_gen.sv
module seq_step_gen #(
  parameter int unsigned NSTEPS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSTEPS-1:0] end_mask,
  output logic [NSTEPS-1:0] step_q
);

  localparam logic [NSTEPS-1:0] FIRST = NSTEPS'(1);

  logic [NSTEPS-1:0] step_d;
  logic              at_end;

  // at the last step of the sequence, or at the top of the ring
  assign at_end = (|(step_q & end_mask)) | step_q[NSTEPS-1];

  always_comb begin
    if (at_end) step_d = FIRST;
    else        step_d = {step_q[NSTEPS-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= FIRST;
    else        step_q <= step_d;
  end

  AST_STEP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(step_q)); // R1

  AST_WRAP_TO_T0: assert property (@(posedge clk) disable iff (!rst_n)
    (|(step_q & end_mask)) |=> step_q[0]); // R10

  AST_FETCH_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    step_q[0] |=> step_q[1]); // R2

endmodule

// File: rtl/seq_op_decode.sv
module seq_op_decode
  import ctl_seq_pkg::*;
#(
  parameter int unsigned OPW    = 5,
  parameter int unsigned NSTEPS = 8,
  parameter int unsigned OP_BR  = 8,
  parameter int unsigned OP_BRL = 9,
  parameter int unsigned OP_SHR = 26
) (
  input  logic [OPW-1:0]    opcode,
  output op_class_t         cls,
  output logic [NSTEPS-1:0] end_mask
);

  localparam logic [OPW-1:0] C_BR  = OPW'(OP_BR);
  localparam logic [OPW-1:0] C_BRL = OPW'(OP_BRL);
  localparam logic [OPW-1:0] C_SHR = OPW'(OP_SHR);

  always_comb begin
    cls       = '0;
    cls.br    = (opcode == C_BR);
    cls.brl   = (opcode == C_BRL);
    cls.shr   = (opcode == C_SHR);
    cls.other = !(cls.br | cls.brl | cls.shr);
  end

  // one entry of end_mask per step: set where this class finishes
  for (genvar k = 0; k < NSTEPS; k++) begin : g_end
    assign end_mask[k] = (cls.br    && (k == LAST_BR))
                       | (cls.brl   && (k == LAST_BRL))
                       | (cls.shr   && (k == LAST_SHR))
                       | (cls.other && (k == LAST_OTHER));
  end

endmodule

// File: rtl/seq_strobe_gen.sv
module seq_strobe_gen
  import ctl_seq_pkg::*;
#(
  parameter int unsigned NSTEPS = 8
) (
  input  logic [NSTEPS-1:0] step,
  input  op_class_t         cls,
  input  logic              cond_bit,
  input  logic              shamt_zero,
  output strobe_t           strb
);

  logic t0, t1, t2, t3, t4, t5, t6;
  logic any_br;

  assign t0 = step[ST_ADDR];
  assign t1 = step[ST_READ];
  assign t2 = step[ST_IR];
  assign t3 = step[ST_EX0];
  assign t4 = step[ST_EX1];
  assign t5 = step[ST_EX2];
  assign t6 = step[ST_EX3];

  assign any_br = cls.br | cls.brl;

  always_comb begin
    strb            = '0;
    // fetch
    strb.mar_load   = t0;
    strb.alu_pass   = t0 | t2;
    strb.pc_inc     = t1;
    strb.mem_read   = t1;
    strb.mar_drive  = t1;
    strb.mbr_load   = t1;
    strb.mbr_drive  = t2;
    strb.ir_load    = t2;
    // program counter
    strb.pc_drive   = t0 | t1 | (t4 & cls.brl & cond_bit);
    strb.pc_load    = t1 | (t4 & cls.br & cond_bit) | (t5 & cls.brl & cond_bit);
    // condition and register file
    strb.cond_load  = t3 & any_br;
    strb.rc_sel     = (t3 & any_br) | (t4 & cls.shr);
    strb.rb_sel     = (t4 & cls.br) | (t5 & cls.brl);
    strb.ra_sel     = (t4 & cls.brl & cond_bit) | (t6 & cls.shr);
    strb.reg_to_bus = (t3 & any_br) | (t4 & cls.br) | (t5 & cls.brl) | (t4 & cls.shr);
    strb.bus_to_reg = (t4 & cls.brl & cond_bit) | (t6 & cls.shr);
    // shifter
    strb.cnt_load   = (t3 & cls.shr) | (t4 & cls.shr & shamt_zero);
    strb.shift_en   = t5 & cls.shr;
    strb.c_load     = t5 & cls.shr;
    strb.c_drive    = t6 & cls.shr;
  end

endmodule

// File: rtl/hw_seq_ctrl.sv
module hw_seq_ctrl
  import ctl_seq_pkg::*;
#(
  parameter int unsigned OPW    = 5,
  parameter int unsigned NSTEPS = 8,
  parameter int unsigned OP_BR  = 8,
  parameter int unsigned OP_BRL = 9,
  parameter int unsigned OP_SHR = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OPW-1:0]    opcode,
  input  logic              cond_bit,
  input  logic              shamt_zero,
  output logic [NSTEPS-1:0] step_o,
  output logic              pc_drive,
  output logic              pc_inc,
  output logic              pc_load,
  output logic              mar_load,
  output logic              mar_drive,
  output logic              mem_read,
  output logic              mbr_load,
  output logic              mbr_drive,
  output logic              ir_load,
  output logic              alu_pass,
  output logic              cond_load,
  output logic              ra_sel,
  output logic              rb_sel,
  output logic              rc_sel,
  output logic              reg_to_bus,
  output logic              bus_to_reg,
  output logic              cnt_load,
  output logic              shift_en,
  output logic              c_load,
  output logic              c_drive
);

  op_class_t         cls;
  logic [NSTEPS-1:0] end_mask;
  logic [NSTEPS-1:0] step;
  strobe_t           strb;

  seq_op_decode #(
    .OPW(OPW), .NSTEPS(NSTEPS), .OP_BR(OP_BR), .OP_BRL(OP_BRL), .OP_SHR(OP_SHR)
  ) u_dec (
    .opcode  (opcode),
    .cls     (cls),
    .end_mask(end_mask)
  );

  seq_step_gen #(.NSTEPS(NSTEPS)) u_step (
    .clk     (clk),
    .rst_n   (rst_n),
    .end_mask(end_mask),
    .step_q  (step)
  );

  seq_strobe_gen #(.NSTEPS(NSTEPS)) u_strb (
    .step      (step),
    .cls       (cls),
    .cond_bit  (cond_bit),
    .shamt_zero(shamt_zero),
    .strb      (strb)
  );

  assign step_o     = step;
  assign pc_drive   = strb.pc_drive;
  assign pc_inc     = strb.pc_inc;
  assign pc_load    = strb.pc_load;
  assign mar_load   = strb.mar_load;
  assign mar_drive  = strb.mar_drive;
  assign mem_read   = strb.mem_read;
  assign mbr_load   = strb.mbr_load;
  assign mbr_drive  = strb.mbr_drive;
  assign ir_load    = strb.ir_load;
  assign alu_pass   = strb.alu_pass;
  assign cond_load  = strb.cond_load;
  assign ra_sel     = strb.ra_sel;
  assign rb_sel     = strb.rb_sel;
  assign rc_sel     = strb.rc_sel;
  assign reg_to_bus = strb.reg_to_bus;
  assign bus_to_reg = strb.bus_to_reg;
  assign cnt_load   = strb.cnt_load;
  assign shift_en   = strb.shift_en;
  assign c_load     = strb.c_load;
  assign c_drive    = strb.c_drive;

  AST_ONE_BUS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({pc_drive, mbr_drive, reg_to_bus, c_drive}) <= 1); // R9

  AST_BR_PC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load && !step[ST_READ]) |-> cond_bit); // R5

  AST_LINK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_to_reg && cls.brl) |-> cond_bit); // R6

  AST_SHIFT_THEN_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && $stable(opcode)) |=> c_drive || !cls.shr); // R7

  AST_UNKNOWN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (step[ST_EX0] && cls.other) |->
      !(pc_load || bus_to_reg || cond_load || cnt_load || c_load)); // R8

endmodule

// File: tb/sim_hw_seq_ctrl.sv
`timescale 1ns/1ps
module sim_hw_seq_ctrl;

  localparam int OPW = 5;
  localparam int NST = 8;
  localparam logic [4:0] OPC_BR  = 5'd8;
  localparam logic [4:0] OPC_BRL = 5'd9;
  localparam logic [4:0] OPC_SHR = 5'd26;

  // bit positions in the 20-bit strobe vector
  localparam int PCD = 19, PCI = 18, PCL = 17, MAL = 16, MAD = 15, MRD = 14;
  localparam int MBL = 13, MBD = 12, IRL = 11, ALP = 10, CDL = 9, RAS = 8;
  localparam int RBS = 7, RCS = 6, R2B = 5, B2R = 4, CNL = 3, SHE = 2;
  localparam int CLD = 1, CDR = 0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [OPW-1:0] opcode = '0;
  logic cond_bit = 1'b0;
  logic shamt_zero = 1'b0;
  logic [NST-1:0] step_o;
  logic pc_drive, pc_inc, pc_load, mar_load, mar_drive, mem_read, mbr_load;
  logic mbr_drive, ir_load, alu_pass, cond_load, ra_sel, rb_sel, rc_sel;
  logic reg_to_bus, bus_to_reg, cnt_load, shift_en, c_load, c_drive;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  typedef struct packed {
    logic [7:0]  step;
    logic [19:0] strb;
    logic [3:0]  req;
  } exp_t;

  exp_t sb_q[$];

  always #2 clk = ~clk;

  hw_seq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .cond_bit(cond_bit),
    .shamt_zero(shamt_zero), .step_o(step_o),
    .pc_drive(pc_drive), .pc_inc(pc_inc), .pc_load(pc_load),
    .mar_load(mar_load), .mar_drive(mar_drive), .mem_read(mem_read),
    .mbr_load(mbr_load), .mbr_drive(mbr_drive), .ir_load(ir_load),
    .alu_pass(alu_pass), .cond_load(cond_load), .ra_sel(ra_sel),
    .rb_sel(rb_sel), .rc_sel(rc_sel), .reg_to_bus(reg_to_bus),
    .bus_to_reg(bus_to_reg), .cnt_load(cnt_load), .shift_en(shift_en),
    .c_load(c_load), .c_drive(c_drive)
  );

  function automatic logic [19:0] got_strb();
    return {pc_drive, pc_inc, pc_load, mar_load, mar_drive, mem_read,
            mbr_load, mbr_drive, ir_load, alu_pass, cond_load, ra_sel,
            rb_sel, rc_sel, reg_to_bus, bus_to_reg, cnt_load, shift_en,
            c_load, c_drive};
  endfunction

  function automatic int seq_len(logic [4:0] op);
    if (op == OPC_BR)  return 5; // R10
    if (op == OPC_BRL) return 6;
    if (op == OPC_SHR) return 7;
    return 4;
  endfunction

  // expected strobes per step, straight from the requirement table
  function automatic logic [19:0] exp_strb(logic [4:0] op, int st, logic c, logic z);
    logic [19:0] e = '0;
    case (st)
      0: begin e[PCD] = 1; e[MAL] = 1; e[ALP] = 1; end                 // R2
      1: begin e[PCD] = 1; e[PCI] = 1; e[PCL] = 1; e[MRD] = 1;
               e[MAD] = 1; e[MBL] = 1; end                               // R3
      2: begin e[MBD] = 1; e[ALP] = 1; e[IRL] = 1; end                 // R4
      default: begin
        if (op == OPC_BR) begin                                         // R5
          if (st == 3) begin e[CDL] = 1; e[RCS] = 1; e[R2B] = 1; end
          if (st == 4) begin e[RBS] = 1; e[R2B] = 1; e[PCL] = c; end
        end else if (op == OPC_BRL) begin                               // R6
          if (st == 3) begin e[CDL] = 1; e[RCS] = 1; e[R2B] = 1; end
          if (st == 4) begin e[RAS] = c; e[B2R] = c; e[PCD] = c; end
          if (st == 5) begin e[RBS] = 1; e[R2B] = 1; e[PCL] = c; end
        end else if (op == OPC_SHR) begin                               // R7
          if (st == 3) e[CNL] = 1;
          if (st == 4) begin e[RCS] = 1; e[R2B] = 1; e[CNL] = z; end
          if (st == 5) begin e[CLD] = 1; e[SHE] = 1; end
          if (st == 6) begin e[CDR] = 1; e[RAS] = 1; e[B2R] = 1; end
        end
        // any other opcode: nothing at step 3 (R8)
      end
    endcase
    return e;
  endfunction

  function automatic logic [3:0] req_of(logic [4:0] op, int st);
    if (st < 3) return 4'(st + 2);
    if (op == OPC_BR)  return 4'd5;
    if (op == OPC_BRL) return 4'd6;
    if (op == OPC_SHR) return 4'd7;
    return 4'd8;
  endfunction

  // driver: called at posedge+1 with the block at step 0
  task automatic run_seq(logic [4:0] op, logic c, logic z);
    opcode = op; cond_bit = c; shamt_zero = z;
    for (int st = 0; st < seq_len(op); st++) begin
      exp_t x;
      x.step = 8'(1) << st;
      x.strb = exp_strb(op, st, c, z);
      x.req  = req_of(op, st);
      sb_q.push_back(x);
      @(posedge clk); #1;
    end
  endtask

  // monitor: compares at the falling edge
  always @(negedge clk) begin
    if (rst_n && sb_q.size() > 0) begin
      exp_t x;
      x = sb_q.pop_front();
      checks++;
      if (step_o !== x.step) begin
        fails++;
        $display("FAIL R10 step: actual %h expected %h (op %0d)", step_o, x.step, opcode);
      end
      checks++;
      if (got_strb() !== x.strb) begin
        fails++;
        $display("FAIL R%0d strobes at step %h: actual %b expected %b",
                 x.req, x.step, got_strb(), x.strb);
      end
      checks++;
      if ($countones({pc_drive, mbr_drive, reg_to_bus, c_drive}) > 1) begin // R9
        fails++;
        $display("FAIL R9 bus sources: actual %b expected at most one high",
                 {pc_drive, mbr_drive, reg_to_bus, c_drive});
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++; // R1 reset state
    if (step_o !== 8'h01) begin
      fails++;
      $display("FAIL R1 reset step: actual %h expected 01", step_o);
    end
    @(posedge clk); #1;
    rst_n = 1'b1;

    // fetch, then each class with both condition levels
    run_seq(OPC_BR, 1'b1, 1'b0);
    run_seq(OPC_BR, 1'b0, 1'b1);
    run_seq(OPC_BRL, 1'b1, 1'b0);
    run_seq(OPC_BRL, 1'b0, 1'b0);
    run_seq(OPC_SHR, 1'b0, 1'b1);
    run_seq(OPC_SHR, 1'b1, 1'b0);
    // unknown opcodes, including edges and neighbours (R8)
    run_seq(5'd0, 1'b1, 1'b1);
    run_seq(5'd31, 1'b1, 1'b1);
    run_seq(5'd7, 1'b0, 1'b1);
    run_seq(5'd10, 1'b1, 1'b0);
    run_seq(5'd25, 1'b1, 1'b1);
    run_seq(5'd27, 1'b0, 1'b0);
    // back to back known after unknown
    run_seq(OPC_BRL, 1'b1, 1'b1);
    run_seq(OPC_SHR, 1'b0, 1'b0);
    run_seq(OPC_BR, 1'b1, 1'b1);

    // R1: reset in the middle of a shift sequence
    opcode = OPC_SHR;
    repeat (5) @(posedge clk);
    #1;
    @(negedge clk);
    checks++;
    if (step_o !== 8'h20) begin
      fails++;
      $display("FAIL R1 pre-reset step: actual %h expected 20", step_o);
    end
    rst_n = 1'b0;
    #0.5;
    checks++;
    if (step_o !== 8'h01) begin
      fails++;
      $display("FAIL R1 mid-sequence reset: actual %h expected 01", step_o);
    end
    @(posedge clk); #1;
    rst_n = 1'b1;
    run_seq(OPC_BR, 1'b0, 1'b0);
    @(negedge clk);
    finished = 1;
    summary();
  end

endmodule